// File: doc/BRIEF.md
# Octant-Folded Scaling-Free Sine/Cosine Generator

This block turns a stream of phase words into cosine (I) and sine (Q) samples for the phase-to-I/Q stage of a low-energy GFSK transmit path. Each phase word spans one full turn. The three most significant bits choose one of eight octants. The block reduces every angle into the base octant [0, pi/4], mirroring the remainder in odd octants. It then narrows the angle to one of eight sub-intervals, each with a precomputed exact start vector. The small angle that remains is removed by a chain of micro-rotations that keep the vector length. The last stage rounds and saturates the rotated vector, then swaps and negates the two parts according to the octant to give the final cos/sin pair.

No micro-rotation changes the vector length by more than a negligible amount. For this reason there is no gain constant to remove and no multiplier anywhere in the datapath. The block accepts one phase per clock with no stall path. At an 8 MHz clock that is eight samples per 1 Mbps symbol. A valid strobe travels alongside the data, so gaps in the input stream appear as gaps in the output stream.

Top module: `octant_sincos`

## Requirements
- R1: The phase `in_phase` is unsigned, with 0x0000 as angle 0 and 2^16 as a full turn. Bits [15:13] give the octant. `out_cos` and `out_sin` stay within 2 LSB of 2047*cos(angle) and 2047*sin(angle). This holds in particular at the phases 0x0000, 0x2000, 0x4000, 0x8000 and 0xC000.
- R2: A new phase is accepted on every clock. The result of a phase sampled at rising edge n is on the outputs after rising edge n+12. The latency is the 10 rotation stages plus 2.
- R3: Both outputs are 12-bit two's complement, limited to the symmetric range -2047..+2047. The code -2048 never appears.
- R4: Adding 0x4000 to a phase (a quarter turn) gives out_cos equal to the negated earlier out_sin, and out_sin equal to the earlier out_cos. The relation is bit-exact.
- R5: For 1 <= r <= 0x1FFF, the outputs for 0x2000+r are exactly the outputs for 0x2000-r with cos and sin swapped.
- R6: For successive phases one LSB apart, each output moves by at most 3 LSB. This includes the wrap from 0xFFFF to 0x0000.
- R7: The reset `rst` is synchronous and active high. While it is high, and on the first cycle after it falls, `out_valid` is 0 and both outputs are 0.
- R8: `out_valid` equals the `in_valid` value sampled 12 rising edges earlier. Inputs marked invalid never produce a high `out_valid`.
- R9: The vector length sqrt(cos^2+sin^2) stays within 2 LSB of 2047 over the whole circle, with no gain-correction step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_phase` as a sample this cycle |
| in_phase | input | 16 | Unsigned phase, full scale one turn |
| out_valid | output | 1 | `in_valid` delayed by the pipeline latency |
| out_cos | output | 12 | Signed in-phase sample, registered |
| out_sin | output | 12 | Signed quadrature sample, registered |

## Verification
Two actions can coincide in one sample: the odd-octant mirror and the clamp of the top sub-interval. A phase that is an exact odd multiple of pi/4, such as 0x2000 or 0x6000, reflects to exactly pi/4. That value overflows the sub-interval field, and the same sample also needs the octant swap on the way out. The bench sends these endpoints back to back with neighbouring mirror pairs (0x2000 -/+ 1 and -/+ 0x1FFF). It judges them by bit-exact swap equality between the mirror partners and by the 2 LSB tolerance against a real-valued reference. A second test crosses the 0xFFFF to 0x0000 wrap within a continuous stream.

// File: rtl/octsc_pkg.sv
`timescale 1ns/1ps
package octsc_pkg;

  localparam real PI_R = 3.14159265358979323846;

  // Angle of one scaling-free micro-rotation (cos ~ 1-2^-(2i+1), sin ~ 2^-i),
  // expressed in phase LSBs with zf extra fractional bits.
  function automatic int rot_angle_fx(input int idx, input int phase_w, input int zf);
    real a;
    a = $atan2(2.0 ** (-idx), 1.0 - 2.0 ** (-2 * idx - 1));
    return $rtoi(a * (2.0 ** phase_w) / (2.0 * PI_R) * (2.0 ** zf) + 0.5);
  endfunction

  // Exact start vector at the centre of sub-interval k of the base octant.
  function automatic int seed_comp(input int k, input int sub_bits, input int mag,
                                   input bit want_sin);
    real ang;
    ang = (real'(k) + 0.5) * (PI_R / 4.0) / (2.0 ** sub_bits);
    if (want_sin) return $rtoi(real'(mag) * $sin(ang) + 0.5);
    return $rtoi(real'(mag) * $cos(ang) + 0.5);
  endfunction

endpackage

// File: rtl/octsc_fold.sv
`timescale 1ns/1ps
module octsc_fold #(
  parameter int PHASE_W  = 16,
  parameter int SUB_BITS = 3,
  parameter int XW       = 19,
  parameter int ZW       = 16,
  parameter int ZF       = 4,
  parameter int MAG      = 131008
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_i,
  input  logic [PHASE_W-1:0]   phase_i,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic signed [ZW-1:0] z_o,
  output logic [2:0]           oct_o,
  output logic                 vld_o
);
  localparam int RES_W  = PHASE_W - 3;
  localparam int FINE_W = RES_W - SUB_BITS;
  localparam int NSUB   = 2 ** SUB_BITS;
  localparam int HALF   = 1 << (FINE_W - 1);
  localparam int LIMIT  = HALF << ZF;

  logic [2:0]           oct;
  logic [RES_W-1:0]     res;
  logic [RES_W:0]       red;
  logic [SUB_BITS-1:0]  sub;
  int                   fine;
  logic signed [XW-1:0] ctab [NSUB];
  logic signed [XW-1:0] stab [NSUB];

  // start vectors, one per sub-interval, computed at elaboration
  for (genvar g = 0; g < NSUB; g++) begin : g_seed
    localparam int CV = octsc_pkg::seed_comp(g, SUB_BITS, MAG, 1'b0);
    localparam int SV = octsc_pkg::seed_comp(g, SUB_BITS, MAG, 1'b1);
    assign ctab[g] = XW'(CV);
    assign stab[g] = XW'(SV);
  end

  always_comb begin
    oct = phase_i[PHASE_W-1 -: 3];
    res = phase_i[RES_W-1:0];
    // odd octants: reflect the remainder about pi/4
    if (oct[0]) red = {1'b1, {RES_W{1'b0}}} - {1'b0, res};
    else        red = {1'b0, res};
    // exactly pi/4 overflows the field: clamp into the top sub-interval
    sub  = red[RES_W] ? {SUB_BITS{1'b1}} : red[RES_W-1 -: SUB_BITS];
    fine = int'(red) - (int'(sub) << FINE_W) - HALF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_o   <= '0;
      y_o   <= '0;
      z_o   <= '0;
      oct_o <= '0;
      vld_o <= 1'b0;
    end else begin
      x_o   <= ctab[sub];
      y_o   <= stab[sub];
      z_o   <= ZW'(fine <<< ZF);
      oct_o <= oct;
      vld_o <= vld_i;
    end
  end

  // R2 / R8: strobe enters the pipe one edge after the input is sampled
  a_r2_front_valid: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vld_o == $past(vld_i)))
    else $error("front valid strobe misaligned");

  // R1: residual angle handed to the rotation chain is centred on the seed
  a_r1_fold_range: assert property (@(posedge clk) disable iff (rst)
    (z_o <= LIMIT) && (z_o >= -LIMIT))
    else $error("folded residual out of sub-interval");

endmodule

// File: rtl/octsc_rot.sv
`timescale 1ns/1ps
module octsc_rot #(
  parameter int XW    = 19,
  parameter int ZW    = 16,
  parameter int IDX   = 5,
  parameter int ALPHA = 5216
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  input  logic [2:0]           oct_i,
  input  logic                 vld_i,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic signed [ZW-1:0] z_o,
  output logic [2:0]           oct_o,
  output logic                 vld_o
);
  localparam int SH2   = 2 * IDX + 1;
  localparam int BOUND = 2 * ALPHA + 4;

  logic signed [XW-1:0] xc, yc, xs, ys, x_n, y_n;
  logic signed [ZW-1:0] z_n;

  always_comb begin
    // second-order cosine term and first-order sine term, shifts only
    xc = x_i - (x_i >>> SH2);
    yc = y_i - (y_i >>> SH2);
    xs = x_i >>> IDX;
    ys = y_i >>> IDX;
    if (z_i[ZW-1]) begin
      x_n = xc + ys;
      y_n = yc - xs;
      z_n = z_i + ZW'(ALPHA);
    end else begin
      x_n = xc - ys;
      y_n = yc + xs;
      z_n = z_i - ZW'(ALPHA);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_o   <= '0;
      y_o   <= '0;
      z_o   <= '0;
      oct_o <= '0;
      vld_o <= 1'b0;
    end else begin
      x_o   <= x_n;
      y_o   <= y_n;
      z_o   <= z_n;
      oct_o <= oct_i;
      vld_o <= vld_i;
    end
  end

  // R1: each stage must shrink the residual to about its own step angle
  a_r1_residual_bound: assert property (@(posedge clk) disable iff (rst)
    (z_o <= BOUND) && (z_o >= -BOUND))
    else $error("residual angle did not converge at stage %0d", IDX);

  // R2: one register per stage for the strobe
  a_r2_stage_valid: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vld_o == $past(vld_i)))
    else $error("stage valid strobe misaligned");

endmodule

// File: rtl/octsc_unfold.sv
`timescale 1ns/1ps
module octsc_unfold #(
  parameter int XW    = 19,
  parameter int OUT_W = 12,
  parameter int GUARD = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [XW-1:0]    x_i,
  input  logic signed [XW-1:0]    y_i,
  input  logic [2:0]              oct_i,
  input  logic                    vld_i,
  output logic signed [OUT_W-1:0] cos_o,
  output logic signed [OUT_W-1:0] sin_o,
  output logic                    vld_o
);
  localparam int LIM = (1 << (OUT_W - 1)) - 1;
  localparam logic signed [XW-1:0]    LIM_X = XW'(LIM);
  localparam logic signed [XW-1:0]    RND   = XW'(1 << (GUARD - 1));
  localparam logic signed [OUT_W-1:0] MINV  = {1'b1, {(OUT_W-1){1'b0}}};

  function automatic logic signed [OUT_W-1:0] shrink(input logic signed [XW-1:0] v);
    logic signed [XW-1:0] r;
    r = (v + RND) >>> GUARD;
    if (r > LIM_X)       r = LIM_X;
    else if (r < -LIM_X) r = -LIM_X;
    return r[OUT_W-1:0];
  endfunction

  logic signed [OUT_W-1:0] c, s, a, b, cos_n, sin_n;
  logic swap, neg_c, neg_s;

  always_comb begin
    c     = shrink(x_i);
    s     = shrink(y_i);
    swap  = oct_i[0] ^ oct_i[1];
    neg_c = oct_i[2] ^ oct_i[1];
    neg_s = oct_i[2];
    a     = swap ? s : c;
    b     = swap ? c : s;
    cos_n = neg_c ? -a : a;
    sin_n = neg_s ? -b : b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cos_o <= '0;
      sin_o <= '0;
      vld_o <= 1'b0;
    end else begin
      cos_o <= cos_n;
      sin_o <= sin_n;
      vld_o <= vld_i;
    end
  end

  // R3: symmetric range, the most negative code is unreachable
  a_r3_no_min: assert property (@(posedge clk) disable iff (rst)
    (cos_o != MINV) && (sin_o != MINV))
    else $error("output reached most negative code");

  // R8: output strobe follows the last pipeline strobe
  a_r8_out_valid: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (vld_o == $past(vld_i)))
    else $error("output valid misaligned");

endmodule

// File: rtl/octant_sincos.sv
`timescale 1ns/1ps
module octant_sincos #(
  parameter int PHASE_W   = 16,
  parameter int OUT_W     = 12,
  parameter int SUB_BITS  = 3,
  parameter int GUARD     = 6,
  parameter int ZF        = 4,
  parameter int FIRST_IDX = 5,
  parameter int LAST_IDX  = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [PHASE_W-1:0]      in_phase,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_cos,
  output logic signed [OUT_W-1:0] out_sin
);
  localparam int NSTG    = LAST_IDX - FIRST_IDX + 1;
  localparam int XW      = OUT_W + GUARD + 1;
  localparam int ZW      = PHASE_W - 3 - SUB_BITS + ZF + 2;
  localparam int MAG     = ((1 << (OUT_W - 1)) - 1) << GUARD;
  localparam int LATENCY = NSTG + 2;
  localparam int A_LAST  = octsc_pkg::rot_angle_fx(LAST_IDX, PHASE_W, ZF);
  localparam int FIN_BND = 2 * A_LAST + 4;

  logic signed [XW-1:0] xs [NSTG+1];
  logic signed [XW-1:0] ys [NSTG+1];
  logic signed [ZW-1:0] zs [NSTG+1];
  logic [2:0]           os [NSTG+1];
  logic                 vs [NSTG+1];

  octsc_fold #(
    .PHASE_W(PHASE_W), .SUB_BITS(SUB_BITS), .XW(XW), .ZW(ZW), .ZF(ZF), .MAG(MAG)
  ) u_fold (
    .clk(clk), .rst(rst), .vld_i(in_valid), .phase_i(in_phase),
    .x_o(xs[0]), .y_o(ys[0]), .z_o(zs[0]), .oct_o(os[0]), .vld_o(vs[0])
  );

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    localparam int STEP = octsc_pkg::rot_angle_fx(FIRST_IDX + g, PHASE_W, ZF);
    octsc_rot #(
      .XW(XW), .ZW(ZW), .IDX(FIRST_IDX + g), .ALPHA(STEP)
    ) u_rot (
      .clk(clk), .rst(rst),
      .x_i(xs[g]), .y_i(ys[g]), .z_i(zs[g]), .oct_i(os[g]), .vld_i(vs[g]),
      .x_o(xs[g+1]), .y_o(ys[g+1]), .z_o(zs[g+1]), .oct_o(os[g+1]), .vld_o(vs[g+1])
    );
  end

  octsc_unfold #(
    .XW(XW), .OUT_W(OUT_W), .GUARD(GUARD)
  ) u_unfold (
    .clk(clk), .rst(rst),
    .x_i(xs[NSTG]), .y_i(ys[NSTG]), .oct_i(os[NSTG]), .vld_i(vs[NSTG]),
    .cos_o(out_cos), .sin_o(out_sin), .vld_o(out_valid)
  );

  // R1: angle left over after the last stage is below about one fine step
  a_r1_final_residual: assert property (@(posedge clk) disable iff (rst)
    (zs[NSTG] <= FIN_BND) && (zs[NSTG] >= -FIN_BND))
    else $error("final residual %0d exceeds bound (latency %0d)", zs[NSTG], LATENCY);

endmodule

// File: tb/sim_octant_sincos.sv
`timescale 1ns/1ps
module sim_octant_sincos;
  localparam int  LAT  = 12;
  localparam real AMP  = 2047.0;
  localparam real PI_R = 3.14159265358979323846;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic [15:0]        in_phase = '0;
  logic               out_valid;
  logic signed [11:0] out_cos, out_sin;

  always #2.5 clk = ~clk;

  octant_sincos u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_phase(in_phase),
    .out_valid(out_valid), .out_cos(out_cos), .out_sin(out_sin)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int failures = 0;
  int n_out = 0;
  int oi [0:1023];
  int oq [0:1023];
  int ocy [0:1023];
  bit vin_hist [0:8191];
  bit ov_hist [0:8191];
  bit done = 1'b0;

  always @(negedge clk) begin
    if (cyc < 8192) ov_hist[cyc] = out_valid;
    if (out_valid && n_out < 1024) begin
      oi[n_out]  = int'(out_cos);
      oq[n_out]  = int'(out_sin);
      ocy[n_out] = cyc;
      n_out = n_out + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int near(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic real ref_c(input logic [15:0] p);
    return AMP * $cos(2.0 * PI_R * real'(p) / 65536.0);
  endfunction

  function automatic real ref_s(input logic [15:0] p);
    return AMP * $sin(2.0 * PI_R * real'(p) / 65536.0);
  endfunction

  task automatic tol_chk(input string req, input string what, input int act,
                         input real expv, input real tol);
    real d;
    d = real'(act) - expv;
    check((d <= tol) && (-d <= tol), req, what, act, near(expv));
  endtask

  task automatic drive(input logic [15:0] p, input bit v);
    @(negedge clk);
    in_phase = p;
    in_valid = v;
    if (cyc < 8192) vin_hist[cyc] = v;
  endtask

  task automatic flush();
    repeat (LAT + 3) drive(16'h0000, 1'b0);
  endtask

  // R7: reset state, including a valid input held during reset
  task automatic t_reset();
    repeat (4) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_phase = 16'h1234;
      check(!out_valid && out_cos == 0 && out_sin == 0, "R7", "outputs during reset",
            int'(out_valid), 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid, "R7", "out_valid after reset", int'(out_valid), 0);
    check(out_cos == 0 && out_sin == 0, "R7", "data after reset", int'(out_cos), 0);
    flush();
  endtask

  // R1: cardinal and octant-boundary phases
  task automatic t_cardinal();
    logic [15:0] pl [6];
    pl = '{16'h0000, 16'h2000, 16'h4000, 16'h8000, 16'hC000, 16'h6000};
    n_out = 0;
    foreach (pl[i]) drive(pl[i], 1'b1);
    flush();
    check(n_out == 6, "R1", "cardinal sample count", n_out, 6);
    foreach (pl[i]) begin
      tol_chk("R1", "cardinal cos", oi[i], ref_c(pl[i]), 2.0);
      tol_chk("R1", "cardinal sin", oq[i], ref_s(pl[i]), 2.0);
    end
  endtask

  // R1, R3, R9: sweep across the full circle
  task automatic t_sweep();
    real m;
    n_out = 0;
    for (int k = 0; k < 256; k++) drive(16'(k * 257), 1'b1);
    flush();
    check(n_out == 256, "R1", "sweep sample count", n_out, 256);
    for (int k = 0; k < 256; k++) begin
      tol_chk("R1", "sweep cos", oi[k], ref_c(16'(k * 257)), 2.0);
      tol_chk("R1", "sweep sin", oq[k], ref_s(16'(k * 257)), 2.0);
      check(oi[k] != -2048 && oq[k] != -2048 && oi[k] <= 2047 && oq[k] <= 2047,
            "R3", "symmetric range", oi[k], 2047);
      m = $sqrt(real'(oi[k] * oi[k] + oq[k] * oq[k]));
      tol_chk("R9", "vector length", near(m), AMP, 2.0);
    end
  endtask

  // R2: latency of a single sample and throughput of a burst
  task automatic t_latency();
    int c0;
    bit ok;
    n_out = 0;
    drive(16'h1000, 1'b1);
    c0 = cyc;
    flush();
    check(n_out == 1, "R2", "single pulse count", n_out, 1);
    check(ocy[0] - c0 == LAT, "R2", "latency", ocy[0] - c0, LAT);
    n_out = 0;
    drive(16'h0000, 1'b1);
    c0 = cyc;
    for (int i = 1; i < 20; i++) drive(16'(i * 1000), 1'b1);
    flush();
    check(n_out == 20, "R2", "burst count", n_out, 20);
    check(ocy[0] - c0 == LAT, "R2", "burst latency", ocy[0] - c0, LAT);
    ok = 1'b1;
    for (int i = 1; i < 20; i++) if (ocy[i] != ocy[0] + i) ok = 1'b0;
    check(ok, "R2", "one sample per clock", int'(ok), 1);
  endtask

  // R8: gaps in the input strobe reappear on the output
  task automatic t_gaps();
    logic [15:0] pat;
    int dc [16];
    pat = 16'hB2D5;
    for (int i = 0; i < 16; i++) begin
      drive(16'(i * 4099), pat[i]);
      dc[i] = cyc;
    end
    flush();
    for (int i = 0; i < 16; i++)
      check(ov_hist[dc[i] + LAT] == pat[i], "R8", "strobe pattern",
            int'(ov_hist[dc[i] + LAT]), int'(pat[i]));
  endtask

  // R4: quarter-turn relation is bit-exact
  task automatic t_quarter();
    logic [15:0] rl [5];
    rl = '{16'h0000, 16'h0123, 16'h1FFF, 16'h2000, 16'h3ABC};
    n_out = 0;
    foreach (rl[j]) begin
      drive(rl[j], 1'b1);
      drive(rl[j] + 16'h4000, 1'b1);
    end
    flush();
    foreach (rl[j]) begin
      check(oi[2*j+1] == -oq[2*j], "R4", "quarter cos", oi[2*j+1], -oq[2*j]);
      check(oq[2*j+1] == oi[2*j], "R4", "quarter sin", oq[2*j+1], oi[2*j]);
    end
  endtask

  // R5: odd-octant mirror around pi/4, including the endpoint clamp
  task automatic t_mirror();
    logic [15:0] rl [5];
    rl = '{16'h0001, 16'h0064, 16'h0800, 16'h1000, 16'h1FFF};
    n_out = 0;
    foreach (rl[j]) begin
      drive(16'h2000 - rl[j], 1'b1);
      drive(16'h2000 + rl[j], 1'b1);
    end
    flush();
    foreach (rl[j]) begin
      check(oi[2*j+1] == oq[2*j], "R5", "mirror cos", oi[2*j+1], oq[2*j]);
      check(oq[2*j+1] == oi[2*j], "R5", "mirror sin", oq[2*j+1], oi[2*j]);
    end
  endtask

  // R6: continuity across the phase wrap
  task automatic t_wrap();
    int d;
    n_out = 0;
    for (int i = 0; i < 17; i++) drive(16'hFFF8 + 16'(i), 1'b1);
    flush();
    check(n_out == 17, "R6", "wrap sample count", n_out, 17);
    for (int i = 1; i < 17; i++) begin
      d = oi[i] - oi[i-1];
      check(d <= 3 && d >= -3, "R6", "cos step", d, 0);
      d = oq[i] - oq[i-1];
      check(d <= 3 && d >= -3, "R6", "sin step", d, 0);
    end
    tol_chk("R6", "sin before wrap", oq[7], ref_s(16'hFFFF), 2.0);
    tol_chk("R6", "sin after wrap", oq[8], ref_s(16'h0000), 2.0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R2 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_cardinal();
    t_sweep();
    t_latency();
    t_gaps();
    t_quarter();
    t_mirror();
    t_wrap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule